// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance-monitoring counter. Every clock it receives per-cycle event counts from a set of event sources. Each source is split into eight sub-event lanes, and each lane carries a 3-bit count. An 8-bit event code picks one source and an 8-bit unit mask picks the lanes of that source to combine. The combined per-cycle count then passes through a qualification stage before it reaches a 40-bit accumulator:

- a threshold compare,
- an optional inversion of that compare,
- an optional rising-edge mode,
- a filter on the current privilege level,
- a global enable.

Software reaches the block through a simple word-wide register port. It writes the configuration word, presets or reads the count in two halves, and clears a sticky overflow flag. The flag drives an interrupt line when the interrupt enable bit is set.

The counter is used by loading a configuration and optionally presetting the count close to its wrap point. The interrupt then fires after a chosen number of qualified events. Software services the interrupt by reading the count and clearing the status flag.

Top module: `perf_event_counter`

## Requirements
- R1: The event code selects source `code` when `code` < NUM_SRC; any other code yields a per-cycle count of 0. The unit mask selects the lanes whose mask bit is 1, and the counts of those lanes are summed. A mask of 0x00 selects all eight lanes. The sum saturates at 7.
- R2: With a threshold field of 0 and edge mode off, the count grows by the full per-cycle count (0 to 7) in each cycle where counting is permitted.
- R3: With a nonzero threshold and inversion off, the count grows by exactly 1 in cycles where the per-cycle count is at least the threshold, and by 0 otherwise.
- R4: With a nonzero threshold and inversion on, the count grows by 1 in cycles where the per-cycle count is below the threshold. With a threshold of 0, the inversion bit has no effect.
- R5: The qualified condition is one of two things. With a nonzero threshold it is the compare result of R3/R4; with a zero threshold it is a nonzero per-cycle count. In both cases it is gated by R6 and R7. In edge mode the count grows by 1 only in a cycle where the qualified condition is true and was false in the previous cycle. A configuration write forces the previous-state register to false.
- R6: At privilege level 0 (`priv_i`=0) counting requires the supervisor enable (config bit 17). At levels 1 to 3 it requires the user enable (config bit 16). With both bits clear the count never grows.
- R7: The global enable (config bit 20) gates all counting. While it is clear the count holds its value.
- R8: Register map:
  - address 0: configuration (code[7:0], mask[15:8], user 16, supervisor 17, edge 18, interrupt enable 19, global enable 20, invert 21, threshold[31:24]);
  - address 1: count bits 31:0;
  - address 2: count bits 39:32 in data bits 7:0;
  - address 3: status, with the overflow flag in bit 0.

  All registers reset to 0. A write to a count half replaces that half, and no increment happens in that cycle. An increment, a write or a configuration change is visible on `rd_data_o` after the next rising clock. A configuration write takes effect from the following cycle.
- R9: A carry out of bit 39 wraps the count modulo 2^40 and sets the sticky overflow flag. `irq_o` equals the overflow flag ANDed with the interrupt enable. Writing 1 to status bit 0 clears the flag, but a new overflow in the same cycle keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_SRC*8*3 | Per-cycle lane counts; lane l of source s at bits [(s*8+l)*3 +: 3] |
| priv_i | input | 2 | Current privilege level, 0 to 3 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational from state) |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The hardest situation to reach from the ports is a wrap of the 40-bit count, because natural counting would need about 2^40 events. The bench presets both count halves to a few events below the top. It then counts through the carry, and it also makes a status clear coincide with a fresh wrap. Edge mode is stressed by holding the qualified condition true across a configuration rewrite, which must produce one more increment. A seeded random phase mixes configurations, privilege levels, lane counts and presets near the wrap point. A behavioural model checks every cycle of it.

// File: rtl/pec_pkg.sv
package pec_pkg;

    // Configuration word as stored in register 0
    typedef struct packed {
        logic [7:0] thresh;
        logic [1:0] spare;
        logic       inv;
        logic       enable;
        logic       int_en;
        logic       edge_md;
        logic       os_en;
        logic       usr_en;
        logic [7:0] umask;
        logic [7:0] code;
    } pec_cfg_t;

    typedef enum logic [1:0] {
        REG_CFG    = 2'd0,
        REG_CNT_LO = 2'd1,
        REG_CNT_HI = 2'd2,
        REG_STAT   = 2'd3
    } pec_addr_e;

endpackage

// File: rtl/pec_event_sel.sv
module pec_event_sel #(
    parameter int NUM_SRC = 4,
    parameter int LANES   = 8,
    parameter int LANE_W  = 3,
    parameter int SUM_W   = 3
) (
    input  logic [NUM_SRC*LANES*LANE_W-1:0] evt_i,
    input  logic [7:0]                      code_i,
    input  logic [LANES-1:0]                umask_i,
    output logic [SUM_W-1:0]                cnt_o
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int ACC_W = LANE_W + $clog2(LANES) + 1;
    localparam int SAT   = (1 << SUM_W) - 1;

    logic [LANE_W-1:0] lane_v [NUM_SRC][LANES];
    logic [LANES-1:0]  lane_pick;
    logic              src_hit;
    logic [IDX_W-1:0]  src_idx;
    logic [ACC_W-1:0]  acc;

    // unpack the flat event bus into source/lane form
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign lane_v[s][l] = evt_i[(s*LANES+l)*LANE_W +: LANE_W];
        end
    end

    always_comb begin
        src_hit   = ({24'd0, code_i} < NUM_SRC);
        src_idx   = code_i[IDX_W-1:0];
        lane_pick = (umask_i == '0) ? '1 : umask_i;
        acc       = '0;
        if (src_hit) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_pick[l]) begin
                    acc = acc + ACC_W'(lane_v[src_idx][l]);
                end
            end
        end
        cnt_o = (acc > ACC_W'(SAT)) ? SUM_W'(SAT) : acc[SUM_W-1:0];
    end

endmodule

// File: rtl/pec_qualify.sv
module pec_qualify #(
    parameter int SUM_W = 3,
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] cnt_i,
    input  logic [THR_W-1:0] thresh_i,
    input  logic             inv_i,
    input  logic             edge_i,
    input  logic             enable_i,
    input  logic             os_en_i,
    input  logic             usr_en_i,
    input  logic [1:0]       priv_i,
    input  logic             clr_prev_i,
    output logic [SUM_W-1:0] inc_o
);
    typedef struct packed {
        logic prev;
    } qual_state_t;

    qual_state_t st_d, st_q;
    logic        priv_ok;
    logic        gate;
    logic        cmp_ge;
    logic        base_cond;
    logic        qual_cond;

    always_comb begin
        st_d      = st_q;
        priv_ok   = (priv_i == 2'd0) ? os_en_i : usr_en_i;
        gate      = enable_i & priv_ok;
        cmp_ge    = ({{THR_W{1'b0}}, cnt_i} >= {{SUM_W{1'b0}}, thresh_i});
        if (thresh_i == '0) begin
            base_cond = (cnt_i != '0);
        end else begin
            base_cond = inv_i ? ~cmp_ge : cmp_ge;
        end
        qual_cond = base_cond & gate;

        if (edge_i) begin
            inc_o = SUM_W'(qual_cond & ~st_q.prev);
        end else if (thresh_i == '0) begin
            inc_o = gate ? cnt_i : '0;
        end else begin
            inc_o = SUM_W'(qual_cond);
        end

        st_d.prev = clr_prev_i ? 1'b0 : qual_cond;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: a held condition never produces a second increment
    assert_edge_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && st_q.prev) |-> (inc_o == '0));

    // R6: no privilege enable, no increment
    assert_priv_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!os_en_i && !usr_en_i) |-> (inc_o == '0));

    // R3: a nonzero threshold turns the increment into a single step
    assert_thresh_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh_i != '0) |-> (inc_o <= SUM_W'(1)));

endmodule

// File: rtl/pec_accum.sv
module pec_accum #(
    parameter int CW     = 40,
    parameter int DATA_W = 32,
    parameter int INC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INC_W-1:0]  inc_i,
    input  logic              ld_lo_i,
    input  logic              ld_hi_i,
    input  logic [DATA_W-1:0] ld_data_i,
    input  logic              clr_ovf_i,
    output logic [CW-1:0]     cnt_o,
    output logic              ovf_o
);
    localparam int HI_W = CW - DATA_W;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ovf;
    } acc_state_t;

    acc_state_t  st_d, st_q;
    logic [CW:0] sum;
    logic        carry;

    always_comb begin
        st_d  = st_q;
        sum   = {1'b0, st_q.cnt} + {{(CW+1-INC_W){1'b0}}, inc_i};
        carry = 1'b0;
        if (ld_lo_i) begin
            st_d.cnt[DATA_W-1:0] = ld_data_i;
        end else if (ld_hi_i) begin
            st_d.cnt[CW-1:DATA_W] = ld_data_i[HI_W-1:0];
        end else begin
            st_d.cnt = sum[CW-1:0];
            carry    = sum[CW];
        end
        st_d.ovf = carry | (st_q.ovf & ~clr_ovf_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;

    // R9: wrapping past the top sets the flag
    assert_wrap_sets_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_lo_i && !ld_hi_i && (st_q.cnt == '1) && (inc_i != '0)) |=> st_q.ovf);

    // R9: the flag stays until cleared
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !clr_ovf_i) |=> st_q.ovf);

    // R8: a low-half preset lands intact
    assert_preset_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo_i |=> (st_q.cnt[DATA_W-1:0] == $past(ld_data_i)));

endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter
    import pec_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int LANES   = 8,
    parameter int LANE_W  = 3,
    parameter int CW      = 40,
    parameter int DATA_W  = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SRC*LANES*LANE_W-1:0] evt_i,
    input  logic [1:0]                      priv_i,
    input  logic                            wr_en_i,
    input  logic [1:0]                      wr_addr_i,
    input  logic [DATA_W-1:0]               wr_data_i,
    input  logic [1:0]                      rd_addr_i,
    output logic [DATA_W-1:0]               rd_data_o,
    output logic                            irq_o
);
    localparam int SUM_W = LANE_W;
    localparam int HI_W  = CW - DATA_W;

    pec_cfg_t         cfg_d, cfg_q;
    logic [SUM_W-1:0] sel_cnt;
    logic [SUM_W-1:0] inc;
    logic [CW-1:0]    cnt;
    logic             ovf;
    logic             wr_cfg, wr_lo, wr_hi, wr_stat;

    always_comb begin
        wr_cfg  = wr_en_i && (wr_addr_i == REG_CFG);
        wr_lo   = wr_en_i && (wr_addr_i == REG_CNT_LO);
        wr_hi   = wr_en_i && (wr_addr_i == REG_CNT_HI);
        wr_stat = wr_en_i && (wr_addr_i == REG_STAT);
        cfg_d   = cfg_q;
        if (wr_cfg) begin
            cfg_d = pec_cfg_t'(wr_data_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    pec_event_sel #(
        .NUM_SRC (NUM_SRC),
        .LANES   (LANES),
        .LANE_W  (LANE_W),
        .SUM_W   (SUM_W)
    ) u_sel (
        .evt_i   (evt_i),
        .code_i  (cfg_q.code),
        .umask_i (cfg_q.umask),
        .cnt_o   (sel_cnt)
    );

    pec_qualify #(
        .SUM_W (SUM_W),
        .THR_W (8)
    ) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_i      (sel_cnt),
        .thresh_i   (cfg_q.thresh),
        .inv_i      (cfg_q.inv),
        .edge_i     (cfg_q.edge_md),
        .enable_i   (cfg_q.enable),
        .os_en_i    (cfg_q.os_en),
        .usr_en_i   (cfg_q.usr_en),
        .priv_i     (priv_i),
        .clr_prev_i (wr_cfg),
        .inc_o      (inc)
    );

    pec_accum #(
        .CW     (CW),
        .DATA_W (DATA_W),
        .INC_W  (SUM_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (inc),
        .ld_lo_i   (wr_lo),
        .ld_hi_i   (wr_hi),
        .ld_data_i (wr_data_i),
        .clr_ovf_i (wr_stat & wr_data_i[0]),
        .cnt_o     (cnt),
        .ovf_o     (ovf)
    );

    always_comb begin
        unique case (pec_addr_e'(rd_addr_i))
            REG_CFG:    rd_data_o = DATA_W'(cfg_q);
            REG_CNT_LO: rd_data_o = cnt[DATA_W-1:0];
            REG_CNT_HI: rd_data_o = {{(DATA_W-HI_W){1'b0}}, cnt[CW-1:DATA_W]};
            default:    rd_data_o = {{(DATA_W-1){1'b0}}, ovf};
        endcase
    end

    assign irq_o = ovf & cfg_q.int_en;

    // R7: with the global enable clear and no write, the count holds
    assert_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.enable && !wr_en_i) |=> $stable(cnt));

    // R9: the interrupt needs its enable
    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cfg_q.int_en && ovf));

    // R1: an out-of-range code contributes nothing
    assert_bad_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ({24'd0, cfg_q.code} >= NUM_SRC) |-> (sel_cnt == '0));

endmodule

// File: tb/sim_perf_event_counter.sv
`timescale 1ns/100ps
module sim_perf_event_counter;
    localparam int NSRC = 4;
    localparam int NL   = 8;
    localparam longint WRAP = 64'd1 << 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC*NL*3-1:0] evt_i = '0;
    logic [1:0]        priv_i = 2'd0;
    logic              wr_en_i = 1'b0;
    logic [1:0]        wr_addr_i = 2'd0;
    logic [31:0]       wr_data_i = '0;
    logic [1:0]        rd_addr_i = 2'd0;
    logic [31:0]       rd_data_o;
    logic              irq_o;

    perf_event_counter u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .priv_i(priv_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    int     total = 0;
    int     bad = 0;
    string  phase = "R8";
    int     lanes [NSRC][NL];
    // behavioural model state
    logic [31:0] m_cfg = '0;
    longint      m_cnt = 0;
    bit          m_ovf = 0;
    bit          m_prev = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_lane(int s, int l, int v);
        lanes[s][l] = v;
        evt_i[(s*NL+l)*3 +: 3] = 3'(v);
    endtask

    task automatic clear_lanes();
        for (int s = 0; s < NSRC; s++)
            for (int l = 0; l < NL; l++) set_lane(s, l, 0);
    endtask

    function automatic int model_sel();
        int code = m_cfg[7:0];
        int mask = m_cfg[15:8];
        int sum = 0;
        if (code >= NSRC) return 0;
        for (int l = 0; l < NL; l++)
            if (mask == 0 || mask[l]) sum += lanes[code][l];
        return (sum > 7) ? 7 : sum;
    endfunction

    // one clock: model next state from inputs, then compare all registers
    task automatic tick();
        int  c, thr, inc;
        bit  gate, base, qc, wc;
        longint nc;
        c    = model_sel();
        thr  = m_cfg[31:24];
        gate = m_cfg[20] && ((priv_i == 0) ? m_cfg[17] : m_cfg[16]);
        base = (thr == 0) ? (c != 0) : (m_cfg[21] ? (c < thr) : (c >= thr));
        qc   = base && gate;
        if (m_cfg[18])      inc = (qc && !m_prev) ? 1 : 0;
        else if (thr == 0)  inc = gate ? c : 0;
        else                inc = qc ? 1 : 0;
        wc = 0;
        @(posedge clk);
        m_prev = qc;
        if (wr_en_i && wr_addr_i == 2'd1) m_cnt = (m_cnt & 64'hFF_0000_0000) | longint'(wr_data_i);
        else if (wr_en_i && wr_addr_i == 2'd2) m_cnt = (m_cnt & 64'hFFFF_FFFF) | (longint'(wr_data_i[7:0]) << 32);
        else begin
            nc = m_cnt + inc;
            if (nc >= WRAP) begin nc -= WRAP; wc = 1; end
            m_cnt = nc;
        end
        if (wr_en_i && wr_addr_i == 2'd3 && wr_data_i[0]) m_ovf = 0;
        if (wc) m_ovf = 1;
        if (wr_en_i && wr_addr_i == 2'd0) begin m_cfg = wr_data_i; m_prev = 0; end
        #0.4;
        rd_addr_i = 2'd1; #0.2; chk({phase, " cnt_lo"}, rd_data_o, m_cnt[31:0]);
        rd_addr_i = 2'd2; #0.2; chk({phase, " cnt_hi"}, rd_data_o, {24'd0, m_cnt[39:32]});
        rd_addr_i = 2'd3; #0.2; chk({phase, " R9 status"}, rd_data_o, {31'd0, m_ovf});
        chk({phase, " R9 irq"}, {31'd0, irq_o}, {31'd0, m_ovf & m_cfg[19]});
        rd_addr_i = 2'd0; #0.2; chk({phase, " cfg"}, rd_data_o, m_cfg);
        wr_en_i = 1'b0;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        tick();
    endtask

    function automatic logic [31:0] mk_cfg(int code, int mask, bit usr, bit os,
                                           bit edg, bit ien, bit en, bit inv, int thr);
        return {8'(thr), 2'b00, inv, en, ien, edg, os, usr, 8'(mask), 8'(code)};
    endfunction

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_lanes();
        #12 rst_n = 1'b1;
        #0.5;
        // R8 reset state
        phase = "R8 reset";
        for (int a = 0; a < 4; a++) begin
            rd_addr_i = 2'(a); #0.2;
            chk("R8 reset read", rd_data_o, 32'd0);
        end
        chk("R9 reset irq", {31'd0, irq_o}, 32'd0);
        @(negedge clk);

        // R1/R2: lanes 2 and 3 of source 1, threshold zero adds full count
        phase = "R1 R2 mask";
        set_lane(1, 2, 2); set_lane(1, 3, 3); set_lane(1, 0, 6);
        wr(2'd0, mk_cfg(1, 8'h0C, 1, 1, 0, 0, 1, 0, 0));
        idle(3);
        phase = "R1 saturate";
        wr(2'd0, mk_cfg(1, 8'h0D, 1, 1, 0, 0, 1, 0, 0));
        idle(2);
        phase = "R1 mask zero";
        set_lane(1, 0, 1);
        wr(2'd0, mk_cfg(1, 8'h00, 1, 1, 0, 0, 1, 0, 0));
        idle(2);
        phase = "R1 bad code";
        wr(2'd0, mk_cfg(9, 8'h00, 1, 1, 0, 0, 1, 0, 0));
        idle(2);
        phase = "R4 inv thr0";
        wr(2'd0, mk_cfg(1, 8'h0C, 1, 1, 0, 0, 1, 1, 0));
        idle(2);

        // R3 threshold compare
        phase = "R3 thresh";
        clear_lanes();
        wr(2'd0, mk_cfg(2, 8'h01, 1, 1, 0, 0, 1, 0, 3));
        for (int v = 0; v < 8; v++) begin set_lane(2, 0, v); tick(); end
        // R4 inverted compare
        phase = "R4 invert";
        wr(2'd0, mk_cfg(2, 8'h01, 1, 1, 0, 0, 1, 1, 3));
        for (int v = 7; v >= 0; v--) begin set_lane(2, 0, v); tick(); end

        // R5 edge mode with held condition and config rewrite
        phase = "R5 edge";
        set_lane(2, 0, 5);
        wr(2'd0, mk_cfg(2, 8'h01, 1, 1, 1, 0, 1, 0, 2));
        idle(4);
        wr(2'd0, mk_cfg(2, 8'h01, 1, 1, 1, 0, 1, 0, 2));
        idle(3);
        set_lane(2, 0, 1); idle(2);
        set_lane(2, 0, 4); idle(2);
        phase = "R5 edge thr0";
        wr(2'd0, mk_cfg(2, 8'h01, 1, 1, 1, 0, 1, 0, 0));
        idle(3);

        // R6 privilege filter
        phase = "R6 priv";
        wr(2'd0, mk_cfg(2, 8'h01, 0, 1, 0, 0, 1, 0, 0));
        for (int p = 0; p < 4; p++) begin priv_i = 2'(p); tick(); end
        wr(2'd0, mk_cfg(2, 8'h01, 1, 0, 0, 0, 1, 0, 0));
        for (int p = 0; p < 4; p++) begin priv_i = 2'(p); tick(); end
        phase = "R6 none";
        wr(2'd0, mk_cfg(2, 8'h01, 0, 0, 0, 0, 1, 0, 0));
        for (int p = 0; p < 4; p++) begin priv_i = 2'(p); tick(); end
        priv_i = 2'd0;

        // R7 global enable off
        phase = "R7 disable";
        wr(2'd0, mk_cfg(2, 8'h01, 1, 1, 0, 0, 0, 0, 0));
        idle(3);

        // R9 overflow, interrupt, clear, set-wins
        phase = "R9 wrap";
        wr(2'd0, mk_cfg(2, 8'h01, 1, 1, 0, 1, 0, 0, 0));
        wr(2'd2, 32'h0000_00FF);
        wr(2'd1, 32'hFFFF_FFF6);
        wr(2'd0, mk_cfg(2, 8'h01, 1, 1, 0, 1, 1, 0, 0));
        idle(4);
        phase = "R9 clear";
        wr(2'd3, 32'h1);
        idle(1);
        phase = "R9 set wins";
        wr(2'd0, mk_cfg(2, 8'h01, 1, 1, 0, 1, 0, 0, 0));
        wr(2'd2, 32'h0000_00FF);
        wr(2'd1, 32'hFFFF_FFFE);
        wr(2'd0, mk_cfg(2, 8'h01, 1, 1, 0, 1, 1, 0, 0));
        wr(2'd3, 32'h1);
        idle(1);
        phase = "R9 irq mask";
        wr(2'd0, mk_cfg(2, 8'h01, 1, 1, 0, 0, 1, 0, 0));
        idle(1);

        // R8 preset while counting takes precedence
        phase = "R8 preset";
        wr(2'd1, 32'h1234_5678);
        wr(2'd2, 32'hFFFF_FFA5);
        idle(2);

        // random phase against the model
        phase = "R1-mix random";
        for (int i = 0; i < 600; i++) begin
            for (int s = 0; s < NSRC; s++)
                for (int l = 0; l < NL; l++) set_lane(s, l, $urandom_range(0, 7) & $urandom_range(0, 7));
            priv_i = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 15) == 0)
                wr(2'd0, mk_cfg($urandom_range(0, 5), ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(0, 255),
                               1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                               ($urandom_range(0, 5) != 0), 1'($urandom), $urandom_range(0, 8)));
            else if ($urandom_range(0, 40) == 0) wr(2'd2, 32'hFF);
            else if ($urandom_range(0, 40) == 0) wr(2'd1, 32'hFFFF_FFF0);
            else if ($urandom_range(0, 30) == 0) wr(2'd3, 32'h1);
            else tick();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule